// File: doc/BRIEF.md
# Key-protected slow clock selector

This block produces the low-speed timebase of a real-time clock as a one-cycle tick enable in the system clock domain. It chooses between two oscillator sources, both presented as single-cycle pulses: an external low-frequency crystal, passed through undivided, and an internal RC oscillator. The internal path is divided twice, first by a fixed pre-divider set at build time and then by a programmable factor of N+1.

Three registers sit on a simple write/read bus. The control register changes only when a 16-bit unlock key comes with the write data. The prescaler register holds N. The gating register lets the tick reach an output pin.

An external-failure flag makes the block fall back to the internal source unless a bypass bit is set. Any change of source or divider waits for the next divided-tick boundary, so that no tick period is ever cut short.

Top module: `slowclk_sel`

## Requirements
- R1: After reset, all three registers read zero and the block runs from the internal source with the programmable factor at one, giving one tick every PRE internal pulses.
- R2: A write to the control register (offset 0x00) is accepted only when write data bits 31:16 equal 0x16AA. With any other key, the stored control bits stay unchanged.
- R3: The control register holds three bits that read back at their written positions: bit 0 is the source select (1 = external), bit 4 is the external enable, and bit 15 is the fallback bypass. All other bits read zero.
- R4: When bit 0 and bit 4 are both set and in effect, each external pulse produces exactly one tick, in the cycle after the pulse, and internal pulses have no effect.
- R5: When the internal source is in effect, one tick is produced for every PRE×(N+1) internal pulses, in the cycle after the last of them. N is bits 4:0 of the prescaler register at offset 0x04, which reads back those 5 bits.
- R6: When the failure flag is high and the bypass bit is clear, the block runs from the internal source, and the stored select bit still reads back 1.
- R7: When the bypass bit is set, the failure flag has no effect, and external pulses keep producing ticks.
- R8: Bit 0 of the gating register at offset 0x60 makes the pin output follow the tick. When the bit is clear, the pin output stays low.
- R9: A new source or divider value takes effect only at a divided-tick boundary of the internal path, or at any cycle while the external path is in effect. A tick period in progress is never shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| xtal_pulse | input | 1 | One-cycle pulse per external crystal period |
| rc_pulse | input | 1 | One-cycle pulse per internal oscillator period |
| xtal_fail | input | 1 | External crystal failure flag |
| tick | output | 1 | Timebase tick enable |
| pin_tick | output | 1 | Gated tick for the output pin |

## Verification
The assertions assume that both oscillator inputs are clean one-cycle-per-period enables synchronous to the system clock. They also assume that the failure flag is a level that the environment holds for whole cycles. The bench drives every input one time unit after a falling edge, so each value is held stable over the rising edge. Internal pulses come in bursts sized to whole divided periods, and the source is switched only after crossing a boundary. The switch points are therefore known. A reference model checks every cycle as well.

// File: rtl/slowclk_sel.sv
module slowclk_sel #(
  parameter int PRE = 32,
  parameter int NW = 5,
  parameter int AW = 8,
  parameter logic [15:0] KEY = 16'h16AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          xtal_pulse,
  input  logic          rc_pulse,
  input  logic          xtal_fail,
  output logic          tick,
  output logic          pin_tick
);

  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_DIV  = AW'(8'h04);
  localparam logic [AW-1:0] A_GATE = AW'(8'h60);
  localparam int PMAX = (PRE > 1) ? PRE - 1 : 0;
  localparam int PW = (PMAX > 1) ? $clog2(PMAX + 1) : 1;

  logic          sel_q, exten_q, byp_q, gate_q;
  logic [NW-1:0] n_q, act_n, div_cnt;
  logic          act_ext;
  logic [PW-1:0] pre_cnt;
  logic          key_ok, want_ext, pre_hit, div_hit, edge_ok;
  logic          unused_bits;

  assign unused_bits = ^reg_wdata;
  assign key_ok   = reg_we && reg_addr == A_CTRL && reg_wdata[31:16] == KEY;
  assign want_ext = sel_q & exten_q & ~(xtal_fail & ~byp_q);
  assign pre_hit  = rc_pulse & (pre_cnt == PW'(PMAX));
  assign div_hit  = ~act_ext & pre_hit & (div_cnt == act_n);
  assign edge_ok  = act_ext | div_hit;
  assign pin_tick = tick & gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0; exten_q <= 1'b0; byp_q <= 1'b0; gate_q <= 1'b0;
      n_q <= '0;
    end else if (reg_we) begin
      if (key_ok) begin
        sel_q   <= reg_wdata[0];
        exten_q <= reg_wdata[4];
        byp_q   <= reg_wdata[15];
      end
      if (reg_addr == A_DIV)  n_q    <= reg_wdata[NW-1:0];
      if (reg_addr == A_GATE) gate_q <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_ext <= 1'b0;
      act_n   <= '0;
      pre_cnt <= '0;
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= act_ext ? xtal_pulse : div_hit;
      if (edge_ok) begin
        act_ext <= want_ext;
        act_n   <= n_q;
      end
      if (act_ext) begin
        pre_cnt <= '0;
        div_cnt <= '0;
      end else if (rc_pulse) begin
        if (pre_hit) begin
          pre_cnt <= '0;
          div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0]  = sel_q;
        reg_rdata[4]  = exten_q;
        reg_rdata[15] = byp_q;
      end
      A_DIV:  reg_rdata[NW-1:0] = n_q;
      A_GATE: reg_rdata[0] = gate_q;
      default: reg_rdata = '0;
    endcase
  end

  // R2: a write without the key leaves the control bits alone
  a_r2_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CTRL && reg_wdata[31:16] != KEY)
      |=> ($stable(sel_q) && $stable(exten_q) && $stable(byp_q)));

  // R4: external pulse becomes a tick in the next cycle
  a_r4_ext_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ext && xtal_pulse) |=> tick);

  // R5: the internal path never ticks without an internal pulse
  a_r5_int_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_ext && !rc_pulse) |=> !tick);

  // R6: failure without bypass leaves the external path
  a_r6_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ext && xtal_fail && !byp_q) |=> !act_ext);

  // R7: with bypass set, a failure keeps the external path
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ext && sel_q && exten_q && byp_q) |=> act_ext);

  // R9: no switch in the middle of an internal period
  a_r9_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_ext && !div_hit) |=> ($stable(act_ext) && $stable(act_n)));

endmodule

// File: tb/test_slowclk_sel.sv
module test_slowclk_sel;
  localparam int PRE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic xtal_pulse = 1'b0, rc_pulse = 1'b0, xtal_fail = 1'b0;
  logic tick, pin_tick;

  int total = 0, bad = 0;
  int tick_cnt = 0, pin_cnt = 0;

  // reference model state
  int m_sel = 0, m_exten = 0, m_byp = 0, m_gate = 0, m_n = 0;
  int m_act_ext = 0, m_act_n = 0, m_pre = 0, m_div = 0, m_tick = 0;

  always #4 clk = ~clk;

  slowclk_sel #(.PRE(PRE)) i_slowclk_sel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xtal_pulse(xtal_pulse),
    .rc_pulse(rc_pulse), .xtal_fail(xtal_fail), .tick(tick), .pin_tick(pin_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rd(input logic [7:0] a);
    if (a == 8'h00) return m_sel | (m_exten << 4) | (m_byp << 15);
    if (a == 8'h04) return m_n;
    if (a == 8'h60) return m_gate;
    return 0;
  endfunction

  always @(posedge clk) begin
    int want, old_n, bnd;
    if (!rst_n) begin
      m_sel = 0; m_exten = 0; m_byp = 0; m_gate = 0; m_n = 0;
      m_act_ext = 0; m_act_n = 0; m_pre = 0; m_div = 0; m_tick = 0;
    end else begin
      want = (m_sel && m_exten && !(xtal_fail && !m_byp)) ? 1 : 0;
      old_n = m_n;
      bnd = 0;
      if (m_act_ext != 0) begin
        m_tick = xtal_pulse ? 1 : 0;
        m_pre = 0; m_div = 0; bnd = 1;
      end else begin
        m_tick = 0;
        if (rc_pulse) begin
          m_pre++;
          if (m_pre >= PRE) begin
            m_pre = 0;
            m_div++;
            if (m_div > m_act_n) begin
              m_div = 0; m_tick = 1; bnd = 1;
            end
          end
        end
      end
      if (bnd != 0) begin
        m_act_ext = want;
        m_act_n = old_n;
      end
      if (reg_we) begin
        if (reg_addr == 8'h00 && reg_wdata[31:16] == 16'h16AA) begin
          m_sel = int'(reg_wdata[0]); m_exten = int'(reg_wdata[4]); m_byp = int'(reg_wdata[15]);
        end
        if (reg_addr == 8'h04) m_n = int'(reg_wdata[4:0]);
        if (reg_addr == 8'h60) m_gate = int'(reg_wdata[0]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(tick == m_tick[0], (m_act_ext != 0) ? "R4 tick" : "R5 tick", int'(tick), m_tick);
      check(pin_tick == (m_tick[0] & m_gate[0]), "R8 pin", int'(pin_tick), m_tick & m_gate);
      check(reg_rdata == exp_rd(reg_addr), "R3 rdata", int'(reg_rdata), exp_rd(reg_addr));
      if (tick) tick_cnt++;
      if (pin_tick) pin_cnt++;
    end
  end

  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input bit rc, input bit xt);
    reg_we = we; reg_addr = a; reg_wdata = d; rc_pulse = rc; xtal_pulse = xt;
    @(negedge clk); #1;
  endtask

  task automatic pulses(input int n, input bit rc, input bit xt);
    for (int i = 0; i < n; i++) step(1'b0, reg_addr, '0, rc, xt);
  endtask

  task automatic peek(input logic [7:0] a, input int exp, input string req);
    reg_we = 1'b0; reg_addr = a; rc_pulse = 1'b0; xtal_pulse = 1'b0;
    #1;
    check(reg_rdata == 32'(exp), req, int'(reg_rdata), exp);
    @(negedge clk); #1;
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    peek(8'h00, 0, "R1 ctrl reset");
    peek(8'h04, 0, "R1 div reset");
    peek(8'h60, 0, "R1 gate reset");

    // R1/R5: PRE*(0+1) pulses per tick
    tick_cnt = 0; pulses(16, 1'b1, 1'b0);
    check(tick_cnt == 4, "R1 reset division", tick_cnt, 4);

    // R9: new N waits for the boundary
    step(1'b1, 8'h04, 32'hFFFF_FFE3, 1'b0, 1'b0);
    peek(8'h04, 3, "R5 prescaler readback");
    tick_cnt = 0; pulses(4, 1'b1, 1'b0);
    check(tick_cnt == 1, "R9 old divider until boundary", tick_cnt, 1);
    tick_cnt = 0; pulses(5, 1'b1, 1'b0);
    step(1'b1, 8'h04, 32'h0, 1'b0, 1'b0);
    pulses(10, 1'b1, 1'b0);
    check(tick_cnt == 0, "R9 no shortened period", tick_cnt, 0);
    pulses(1, 1'b1, 1'b0);
    check(tick_cnt == 1, "R5 divide by 16", tick_cnt, 1);
    tick_cnt = 0; pulses(4, 1'b1, 1'b0);
    check(tick_cnt == 1, "R5 divide by 4", tick_cnt, 1);

    // R2/R3: key protection and field positions
    step(1'b1, 8'h00, 32'h1234_0011, 1'b0, 1'b0);
    peek(8'h00, 0, "R2 bad key ignored");
    step(1'b1, 8'h00, 32'h16AA_FFFF, 1'b0, 1'b0);
    peek(8'h00, 32'h8011, "R3 ctrl fields");

    // R4: switch at boundary, then external ticks
    pulses(4, 1'b1, 1'b0);
    tick_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 8'h00, '0, 1'b1, 1'b1);
      step(1'b0, 8'h00, '0, 1'b1, 1'b0);
    end
    check(tick_cnt == 10, "R4 external ticks", tick_cnt, 10);

    // R7: bypass set, failure ignored
    xtal_fail = 1'b1;
    tick_cnt = 0; pulses(6, 1'b0, 1'b1);
    check(tick_cnt == 6, "R7 bypass keeps external", tick_cnt, 6);

    // R6: clear bypass, failure forces internal
    step(1'b1, 8'h00, 32'h16AA_0011, 1'b0, 1'b0);
    step(1'b0, 8'h00, '0, 1'b0, 1'b0);
    tick_cnt = 0; pulses(6, 1'b0, 1'b1);
    check(tick_cnt == 0, "R6 fallback to internal", tick_cnt, 0);
    peek(8'h00, 32'h11, "R6 stored select kept");
    tick_cnt = 0; pulses(4, 1'b1, 1'b0);
    check(tick_cnt == 1, "R6 internal ticks during failure", tick_cnt, 1);
    xtal_fail = 1'b0;
    pulses(4, 1'b1, 1'b0);

    // R8: output gate
    step(1'b1, 8'h60, 32'h1, 1'b0, 1'b0);
    peek(8'h60, 1, "R8 gate readback");
    tick_cnt = 0; pin_cnt = 0; pulses(5, 1'b0, 1'b1);
    check(pin_cnt == 5, "R8 pin follows tick", pin_cnt, 5);
    step(1'b1, 8'h60, 32'h0, 1'b0, 1'b0);
    pin_cnt = 0; tick_cnt = 0; pulses(5, 1'b0, 1'b1);
    check(pin_cnt == 0, "R8 pin gated off", pin_cnt, 0);
    check(tick_cnt == 5, "R4 tick while gated", tick_cnt, 5);

    pulses(3, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule